// File: doc/BRIEF.md
# Parallel Bus Register Slave

This block sits on the peripheral side of a simple microprocessor parallel bus. It has an 8-bit address input, an 8-bit data bus that both sides use, and five control lines: an active-high master reset, separate active-low write and read strobes, and two active-low module selects. A parameter chooses which of the two selects belongs to this instance. Any access on the other select is ignored.

Writes pass through a local-clock synchronizer. When the write strobe falls while this module is selected, the block captures the bus address and data once. On the next clock it stores the data into one of eight registers. Reads need no clock. While the read strobe and this module's select are both low, the output enable rises and the addressed register appears on the data output. Addresses with any bit set above the low three read as 0x00, and writes to them are dropped. All eight registers are also driven out as one flat vector for a neighbouring peripheral.

Master reset wins over any access. It clears the registers and the synchronizer state at once, without waiting for a clock edge. Its release is synchronized to the local clock.

Top module: `pbus_regslave`

## Requirements
- R1: While `mreset` is high, every register reads as 0x00 on `regs_flat`, the clear takes effect without waiting for a clock edge, `data_oe` is low, and a write strobe held during reset stores nothing.
- R2: A write strobe (`wr_n` low) with this module's select low stores the `data_in` byte into register `addr[2:0]`. The result shows on `regs_flat` within six clocks of the strobe falling. Registers do not change while `wr_n` stays high.
- R3: While `rd_n` is low, `wr_n` is high and this module's select is low, `data_oe` is 1 and `data_out` equals register `addr[2:0]`, with no clock needed.
- R4: When `rd_n` is high, or this module's select is high, `data_oe` is 0 and `data_out` is 0x00.
- R5: The instance answers only to `sel_n[SEL_IDX]`. A read or write through the other select bit leaves all registers unchanged and never raises `data_oe`.
- R6: If any of `addr[7:3]` is nonzero, a write changes no register, and a read drives `data_oe` high with `data_out` = 0x00.
- R7: If `rd_n` and `wr_n` are low together, `data_oe` stays 0 and no register changes.
- R8: Register i appears on `regs_flat[8*i+7:8*i]`.
- R9: Each falling edge of the write strobe commits exactly once, using the data present when the edge was seen. A later change of `data_in` while the strobe is still held low does not alter the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock used to sample the strobes |
| mreset | input | 1 | Master reset, active high, asserted asynchronously |
| addr | input | 8 | Register address driven by the master |
| data_in | input | 8 | Data bus value as seen at the pad |
| data_out | output | 8 | Value this block drives onto the data bus |
| data_oe | output | 1 | Data bus output enable; low releases the bus |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| sel_n | input | 2 | Module selects, active low; bit SEL_IDX is this instance's |
| regs_flat | output | 64 | All eight registers side by side, register 0 in the low byte |

## Verification
Two cases are hard to reach from the ports. The first is a strobe held low across many clocks while the data under it changes, since only the first synchronized edge may commit. The bench holds the write strobe for twelve clocks, swaps `data_in` halfway through, and then issues a fresh strobe to show that a new edge does commit. The second is reset priority. A write strobe is held against an active master reset, and the clear is observed before any clock edge passes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned PB_ADDR_W = 8;
  localparam int unsigned PB_DATA_W = 8;
  localparam int unsigned PB_REG_AW = 3;
  localparam int unsigned PB_SYNC_N = 2;

  // synchronized control levels, all active high
  typedef struct packed {
    logic act_wr;
    logic act_rd;
    logic act_sel;
  } pb_ctl_t;
endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async,
  output logic rst_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) chain_q <= '1;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pbus_wr_detect.sv
module pbus_wr_detect
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W = PB_ADDR_W,
  parameter int unsigned DATA_W = PB_DATA_W,
  parameter int unsigned REG_AW = PB_REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  pb_ctl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              we,
  output logic [REG_AW-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  logic wr_prev_q;
  logic fire;
  logic in_win;

  assign in_win = (addr[ADDR_W-1:REG_AW] == '0);
  assign fire   = ctl.act_wr & ~wr_prev_q & ctl.act_sel & ~ctl.act_rd;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_prev_q <= 1'b0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      wr_prev_q <= ctl.act_wr;
      we        <= fire & in_win;
      if (fire) begin
        waddr <= addr[REG_AW-1:0];
        wdata <= data;
      end
    end
  end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_AW = 3,
  localparam int unsigned NREG  = 1 << REG_AW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [REG_AW-1:0]      waddr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [REG_AW-1:0]      raddr,
  output logic [DATA_W-1:0]      rdata,
  output logic [NREG*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                              reg_q[g] <= '0;
      else if (we && waddr == REG_AW'(g))   reg_q[g] <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = reg_q[g];
  end

  assign rdata = reg_q[raddr];
endmodule

// File: rtl/pbus_regslave.sv
module pbus_regslave
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W      = PB_ADDR_W,
  parameter int unsigned DATA_W      = PB_DATA_W,
  parameter int unsigned REG_AW      = PB_REG_AW,
  parameter int unsigned SYNC_STAGES = PB_SYNC_N,
  parameter int unsigned SEL_IDX     = 0,
  localparam int unsigned NREG       = 1 << REG_AW
) (
  input  logic                   clk,
  input  logic                   mreset,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      data_in,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_oe,
  input  logic                   wr_n,
  input  logic                   rd_n,
  input  logic [1:0]             sel_n,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic              rst_int;
  logic [2:0]        ctl_raw;
  logic [2:0]        ctl_q;
  pb_ctl_t           ctl_s;
  logic              we;
  logic [REG_AW-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              own_sel;
  logic              rd_hit;
  logic              rd_in_win;

  pbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_async(mreset), .rst_o(rst_int)
  );

  assign own_sel = ~sel_n[SEL_IDX];
  assign ctl_raw = {~wr_n, ~rd_n, own_sel};

  pbus_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst(rst_int), .d(ctl_raw), .q(ctl_q)
  );
  assign ctl_s = pb_ctl_t'(ctl_q);

  pbus_wr_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_wr (
    .clk(clk), .rst(rst_int), .ctl(ctl_s), .addr(addr), .data(data_in),
    .we(we), .waddr(waddr), .wdata(wdata)
  );

  pbus_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst_int), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(addr[REG_AW-1:0]), .rdata(rdata), .flat(regs_flat)
  );

  // read path is combinational from the strobes; reset and a write conflict block it
  assign rd_hit    = ~rd_n & own_sel & wr_n & ~mreset;
  assign rd_in_win = (addr[ADDR_W-1:REG_AW] == '0);
  assign data_oe   = rd_hit;
  assign data_out  = (rd_hit && rd_in_win) ? rdata : '0;
endmodule

// File: rtl/pbus_regslave_chk.sv
module pbus_regslave_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REG_AW  = 3,
  parameter int unsigned SEL_IDX = 0,
  localparam int unsigned NREG   = 1 << REG_AW
) (
  input logic                   clk,
  input logic                   mreset,
  input logic [ADDR_W-1:0]      addr,
  input logic [DATA_W-1:0]      data_out,
  input logic                   data_oe,
  input logic                   wr_n,
  input logic                   rd_n,
  input logic [1:0]             sel_n,
  input logic [NREG*DATA_W-1:0] regs_flat
);
  always @(negedge clk) begin
    if (mreset == 1'b1) begin
      assert_reset_clears_R1: assert (regs_flat == '0 && !data_oe);
    end
  end

  assert_quiet_regs_R2: assert property (@(posedge clk) disable iff (mreset)
    (wr_n && $past(wr_n) && $past(wr_n, 2) && $past(wr_n, 3) && $past(wr_n, 4))
      |-> $stable(regs_flat));

  assert_bus_released_R4: assert property (@(posedge clk) disable iff (mreset)
    rd_n |-> (!data_oe && data_out == '0));

  assert_other_select_R5: assert property (@(posedge clk) disable iff (mreset)
    sel_n[SEL_IDX] |-> !data_oe);

  assert_window_zero_R6: assert property (@(posedge clk) disable iff (mreset)
    (data_oe && addr[ADDR_W-1:REG_AW] != '0) |-> data_out == '0);

  assert_conflict_undriven_R7: assert property (@(posedge clk) disable iff (mreset)
    !wr_n |-> !data_oe);
endmodule

bind pbus_regslave pbus_regslave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .SEL_IDX(SEL_IDX)
) u_chk (
  .clk(clk), .mreset(mreset), .addr(addr), .data_out(data_out),
  .data_oe(data_oe), .wr_n(wr_n), .rd_n(rd_n), .sel_n(sel_n),
  .regs_flat(regs_flat)
);

// File: tb/pbus_regslave_bench.sv
`timescale 1ns/1ps
module pbus_regslave_bench;
  logic        clk = 1'b0;
  logic        mreset = 1'b1;
  logic [7:0]  addr = '0;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_oe;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [1:0]  sel_n = 2'b11;
  logic [63:0] regs_flat;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] exp_reg [8];

  always #4 clk = ~clk;

  pbus_regslave u_pbus_regslave (
    .clk(clk), .mreset(mreset), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .wr_n(wr_n), .rd_n(rd_n),
    .sel_n(sel_n), .regs_flat(regs_flat)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all_regs(input string req);
    for (int i = 0; i < 8; i++) chk(req, 64'(regs_flat[i*8 +: 8]), 64'(exp_reg[i]));
  endtask

  // strobe a write through select bit s, holding the strobe for 6 clocks
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input int s);
    @(negedge clk);
    addr = a; data_in = d; sel_n = 2'b11; sel_n[s] = 1'b0; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1; sel_n = 2'b11;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, input int s, input logic oe_exp,
                          input logic [7:0] d_exp, input string req);
    @(negedge clk);
    addr = a; sel_n = 2'b11; sel_n[s] = 1'b0; rd_n = 1'b0;
    #1;
    chk(req, 64'(data_oe), 64'(oe_exp));
    chk(req, 64'(data_out), 64'(d_exp));
    rd_n = 1'b1; sel_n = 2'b11;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1..R9 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_reg[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 regs in reset", regs_flat, 64'h0);
    chk("R1 oe in reset", 64'(data_oe), 64'h0);
    mreset = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 idle oe", 64'(data_oe), 64'h0);

    // R2 R8: write every register, check flat slices, then R3 bus readback
    for (int i = 0; i < 8; i++) begin
      exp_reg[i] = 8'((i * 37 + 5) ^ 8'hC3);
      bus_write(8'(i), exp_reg[i], 0);
    end
    chk_all_regs("R8 flat slice after sweep");
    for (int i = 0; i < 8; i++) bus_read(8'(i), 0, 1'b1, exp_reg[i], "R3 read sweep");

    // R4: strobes without full qualification release the bus
    @(negedge clk); addr = 8'h2; rd_n = 1'b0; sel_n = 2'b11; #1;
    chk("R4 rd without select oe", 64'(data_oe), 64'h0);
    chk("R4 rd without select data", 64'(data_out), 64'h0);
    rd_n = 1'b1; sel_n[0] = 1'b0; #1;
    chk("R4 select without rd oe", 64'(data_oe), 64'h0);
    sel_n = 2'b11;

    // R5: other select bit ignored for write and read
    bus_write(8'h2, 8'hAA, 1);
    chk_all_regs("R5 write on other select");
    bus_read(8'h2, 1, 1'b0, 8'h00, "R5 read on other select");

    // R6: addresses outside the window
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a;
      a = (k == 5) ? 8'hFF : 8'(8 << k) | 8'(k);
      bus_write(a, 8'h5A, 0);
      chk_all_regs("R6 write outside window");
      bus_read(a, 0, 1'b1, 8'h00, "R6 read outside window");
    end

    // R7: both strobes low together
    @(negedge clk);
    addr = 8'h1; data_in = 8'h11; sel_n = 2'b10; rd_n = 1'b0; wr_n = 1'b0; #1;
    chk("R7 conflict oe", 64'(data_oe), 64'h0);
    repeat (6) @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; sel_n = 2'b11;
    repeat (2) @(negedge clk);
    chk_all_regs("R7 conflict no write");

    // R9: long strobe with data changing under it commits once
    @(negedge clk);
    addr = 8'h3; data_in = 8'h77; sel_n = 2'b10; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    data_in = 8'h99;
    repeat (6) @(negedge clk);
    wr_n = 1'b1; sel_n = 2'b11;
    repeat (2) @(negedge clk);
    exp_reg[3] = 8'h77;
    chk_all_regs("R9 single commit");
    bus_write(8'h3, 8'h99, 0);
    exp_reg[3] = 8'h99;
    chk("R2 new strobe commits", 64'(regs_flat[31:24]), 64'h99);

    // R1: reset wins over a held write, clears with no clock edge
    @(negedge clk);
    addr = 8'h4; data_in = 8'hEE; sel_n = 2'b10; wr_n = 1'b0;
    #1 mreset = 1'b1; #1;
    chk("R1 async clear", regs_flat, 64'h0);
    repeat (6) @(negedge clk);
    wr_n = 1'b1; sel_n = 2'b11;
    @(negedge clk); mreset = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) exp_reg[i] = 8'h00;
    chk_all_regs("R1 write during reset dropped");
    bus_write(8'h4, 8'h3C, 0);
    exp_reg[4] = 8'h3C;
    chk_all_regs("R2 write after reset");

    finish_run();
  end
endmodule